// File: doc/BRIEF.md
# SAR ADC Conversion Timing Controller

This block is the digital sequencer that sits around a successive-approximation converter. It runs on a clock at twice the converter clock rate, so every timing count is in half-cycles of the converter clock. A start request moves it out of idle into a sampling phase, with the sample/hold switch closed. It then enters a conversion phase in which it steps a trial code through the result bits, most significant bit first, and reads a comparator input after each step. After a fixed write latency it loads the result into a data register.

The sampling length comes from a 3-bit select. The conversion length comes from a 2-bit resolution select. Both selects are captured when a conversion begins. Two sticky flags mark the start of the hold and the arrival of a result. Each flag is cleared by writing a 1 to it, and a set event wins over a clear in the same cycle. In single mode the block goes back to idle after one result. In continuous mode it starts sampling the next channel index straight away. The results interface is a plain register with a flag and has no back-pressure. A result that is not read before the next one arrives is overwritten, and the flag stays set.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, busy_o, sample_o, bit_stb_o, eosmp_o and eoc_o are 0, and data_o and chan_o are 0.
- R2: smp_sel_i values 0 to 7 select sampling lengths of 3, 7, 15, 25, 39, 79, 159 and 321 half-cycles. sample_o is high for exactly that many cycles, starting in the cycle after start_i is accepted. eosmp_o sets on the edge that ends sampling.
- R3: res_sel_i values 0 to 3 select 12, 10, 8 and 6 result bits. The conversion phase lasts 2×bits+1 half-cycles (25, 21, 17 or 13). bit_stb_o pulses once every second cycle, bits times in all, and never while sample_o is high.
- R4: data_o and eoc_o update on the same edge, two half-cycles after the conversion phase ends. eoc_o therefore rises exactly sampling + conversion + 2 cycles after start is accepted.
- R5: At each bit strobe, the bit under trial is kept when cmp_i is 1 while dac_o shows the trial code. The result is right-aligned, and the bits above the selected resolution are 0.
- R6: data_o keeps the previous result until the R4 update.
- R7: eosmp_clr_i and eoc_clr_i clear their flags when high. A set event in the same cycle as a clear leaves the flag set.
- R8: start_i is ignored while busy_o is high. It neither restarts nor lengthens the conversion, and it does not start another one.
- R9: smp_sel_i and res_sel_i are captured when sampling begins. Changes made during a conversion have no effect on that conversion.
- R10: chan_o advances by 1, modulo NUM_CH, with each result. With cont_i low, busy_o drops on the result edge. With cont_i high, sampling of the next channel begins on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock rate |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| cont_i | input | 1 | Continuous mode select |
| smp_sel_i | input | 3 | Sampling-length select |
| res_sel_i | input | 2 | Resolution select |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| eosmp_clr_i | input | 1 | Clear for the end-of-sampling flag |
| eoc_clr_i | input | 1 | Clear for the end-of-conversion flag |
| busy_o | output | 1 | A conversion is in progress |
| sample_o | output | 1 | Sample/hold switch closed |
| bit_stb_o | output | 1 | Bit-decision strobe |
| dac_o | output | 12 | Trial code during conversion, 0 otherwise |
| data_o | output | 12 | Result register |
| eosmp_o | output | 1 | End-of-sampling flag |
| eoc_o | output | 1 | End-of-conversion flag |
| chan_o | output | CH_W | Channel index |

## Verification
The hardest case to reach is a flag clear that arrives on the very edge where hardware sets the flag. The bench gets there by holding the end-of-sampling clear high from the start request until the computed hold edge, so the two collide by construction of the stimulus. Changes to the config and a repeat start in the middle of a conversion are also hard to reach. Random runs inject both at a fixed offset after the start, and the bench checks the timing against the selects that were applied at the start. Random channel counts run past NUM_CH so that the channel index wraps.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int MAX_BITS = 12;
  localparam int CNT_W    = 9;

  typedef enum logic [1:0] {PH_IDLE, PH_SMP, PH_CONV, PH_WLAT} phase_t;

  function automatic logic [CNT_W-1:0] smp_halves(input logic [2:0] sel);
    logic [CNT_W-1:0] r;
    case (sel)
      3'd0: r = 9'd3;
      3'd1: r = 9'd7;
      3'd2: r = 9'd15;
      3'd3: r = 9'd25;
      3'd4: r = 9'd39;
      3'd5: r = 9'd79;
      3'd6: r = 9'd159;
      default: r = 9'd321;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] res_bits(input logic [1:0] sel);
    logic [3:0] r;
    case (sel)
      2'd0: r = 4'd12;
      2'd1: r = 4'd10;
      2'd2: r = 4'd8;
      default: r = 4'd6;
    endcase
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] sar_halves(input logic [1:0] sel);
    return CNT_W'({res_bits(sel), 1'b1});
  endfunction
endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            cont_i,
  input  logic [2:0]      smp_sel_i,
  input  logic [1:0]      res_sel_i,
  output logic            busy_o,
  output logic            sample_o,
  output logic            hold_o,
  output logic            conv_o,
  output logic            strobe_o,
  output logic [3:0]      bit_idx_o,
  output logic            wr_o,
  output logic [CH_W-1:0] chan_o
);
  phase_t           st;
  logic [CNT_W-1:0] cnt, smp_len_q, sar_len_q;
  logic [3:0]       bits_q;
  logic             sar_end;

  always_comb begin
    busy_o    = (st != PH_IDLE);
    sample_o  = (st == PH_SMP);
    conv_o    = (st == PH_CONV);
    hold_o    = sample_o && (cnt == smp_len_q - CNT_W'(1));
    sar_end   = conv_o && (cnt == sar_len_q - CNT_W'(1));
    wr_o      = (st == PH_WLAT) && (cnt == CNT_W'(1));
    strobe_o  = conv_o && !cnt[0] && (cnt < CNT_W'({bits_q, 1'b0}));
    bit_idx_o = bits_q - 4'd1 - cnt[4:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PH_IDLE;
      cnt       <= '0;
      smp_len_q <= '0;
      sar_len_q <= '0;
      bits_q    <= '0;
      chan_o    <= '0;
    end else begin
      case (st)
        PH_IDLE: if (start_i) begin
          st        <= PH_SMP;
          cnt       <= '0;
          smp_len_q <= smp_halves(smp_sel_i);
          sar_len_q <= sar_halves(res_sel_i);
          bits_q    <= res_bits(res_sel_i);
        end
        PH_SMP: if (hold_o) begin
          st  <= PH_CONV;
          cnt <= '0;
        end else cnt <= cnt + CNT_W'(1);
        PH_CONV: if (sar_end) begin
          st  <= PH_WLAT;
          cnt <= '0;
        end else cnt <= cnt + CNT_W'(1);
        default: if (wr_o) begin
          chan_o <= (chan_o == CH_W'(NUM_CH - 1)) ? '0 : chan_o + CH_W'(1);
          cnt    <= '0;
          if (cont_i) begin
            st        <= PH_SMP;
            smp_len_q <= smp_halves(smp_sel_i);
            sar_len_q <= sar_halves(res_sel_i);
            bits_q    <= res_bits(res_sel_i);
          end else st <= PH_IDLE;
        end else cnt <= cnt + CNT_W'(1);
      endcase
    end
  end

  // R2
  smp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (cnt < smp_len_q));

  // R8
  smp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && $past(st) == PH_SMP) |-> (cnt == $past(cnt) + CNT_W'(1)));

  // R3
  conv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_o && $past(st) != PH_CONV) |-> ($past(st) == PH_SMP));

  // R4
  wr_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> ($past(st, 2) == PH_CONV));
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
  import adc_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                conv_i,
  input  logic                strobe_i,
  input  logic [3:0]          bit_idx_i,
  input  logic                cmp_i,
  input  logic                wr_i,
  output logic [MAX_BITS-1:0] dac_o,
  output logic [MAX_BITS-1:0] data_o
);
  logic [MAX_BITS-1:0] acc, sel_bit;

  for (genvar b = 0; b < MAX_BITS; b++) begin : g_bit
    assign sel_bit[b] = (bit_idx_i == 4'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              acc[b] <= 1'b0;
      else if (clr_i)                          acc[b] <= 1'b0;
      else if (strobe_i && sel_bit[b] && cmp_i) acc[b] <= 1'b1;
    end
  end

  assign dac_o = conv_i ? (acc | sel_bit) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_o <= '0;
    else if (wr_i) data_o <= acc;
  end

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_i) |-> $stable(data_o));

  // R5
  bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe_i) && $past(cmp_i)) |-> ((acc & $past(sel_bit)) != '0));
endmodule

// File: rtl/adc_status_flags.sv
module adc_status_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);

    // R7
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                cont_i,
  input  logic [2:0]          smp_sel_i,
  input  logic [1:0]          res_sel_i,
  input  logic                cmp_i,
  input  logic                eosmp_clr_i,
  input  logic                eoc_clr_i,
  output logic                busy_o,
  output logic                sample_o,
  output logic                bit_stb_o,
  output logic [MAX_BITS-1:0] dac_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                eosmp_o,
  output logic                eoc_o,
  output logic [CH_W-1:0]     chan_o
);
  logic       hold, conv, wr;
  logic [3:0] bit_idx;
  logic [1:0] flags;

  adc_phase_timer #(.NUM_CH(NUM_CH), .CH_W(CH_W)) timer_i (
    .clk, .rst_n, .start_i, .cont_i, .smp_sel_i, .res_sel_i,
    .busy_o, .sample_o, .hold_o(hold), .conv_o(conv),
    .strobe_o(bit_stb_o), .bit_idx_o(bit_idx), .wr_o(wr), .chan_o
  );

  adc_sar_engine sar_i (
    .clk, .rst_n, .clr_i(hold), .conv_i(conv), .strobe_i(bit_stb_o),
    .bit_idx_i(bit_idx), .cmp_i, .wr_i(wr), .dac_o, .data_o
  );

  adc_status_flags #(.N(2)) flags_i (
    .clk, .rst_n, .set_i({wr, hold}), .clr_i({eoc_clr_i, eosmp_clr_i}),
    .flag_o(flags)
  );

  assign eosmp_o = flags[0];
  assign eoc_o   = flags[1];

  // R3
  strobe_not_sampling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |-> !sample_o);

  // R4
  eoc_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eoc_o) && busy_o && !sample_o) |-> 1'b0);
endmodule

// File: tb/adc_conv_seq_tb_top.sv
`timescale 1ns/1ps
module adc_conv_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, cont_i = 1'b0;
  logic [2:0]  smp_sel_i = '0;
  logic [1:0]  res_sel_i = '0;
  logic        eosmp_clr_i = 1'b0, eoc_clr_i = 1'b0;
  logic        busy_o, sample_o, bit_stb_o, eosmp_o, eoc_o, cmp_i;
  logic [11:0] dac_o, data_o, target = '0;
  logic [3:0]  chan_o;
  int checks = 0, fails = 0;
  int exp_chan = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign cmp_i = (dac_o <= target);

  adc_conv_seq dut_i (
    .clk, .rst_n, .start_i, .cont_i, .smp_sel_i, .res_sel_i, .cmp_i,
    .eosmp_clr_i, .eoc_clr_i, .busy_o, .sample_o, .bit_stb_o, .dac_o,
    .data_o, .eosmp_o, .eoc_o, .chan_o
  );

  function automatic int exp_smp(input logic [2:0] s);
    int t[8] = '{3, 7, 15, 25, 39, 79, 159, 321};
    return t[s];
  endfunction
  function automatic int exp_bits(input logic [1:0] r);
    return 12 - 2 * int'(r);
  endfunction
  function automatic int exp_sar(input logic [1:0] r);
    return 2 * exp_bits(r) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [2:0] s, input logic [1:0] r,
                          input logic [11:0] tgt, input bit disturb, input bit hold_clr);
    int n = 0, smp_n = -1, samples = 0, strobes = 0, held_bad = 0;
    int smp_e = exp_smp(s), tot_e = exp_smp(s) + exp_sar(r) + 2;
    logic [11:0] prev = data_o;
    target = tgt; smp_sel_i = s; res_sel_i = r;
    @(negedge clk); start_i = 1'b1; eosmp_clr_i = hold_clr;
    @(negedge clk); start_i = 1'b0;
    eosmp_clr_i = hold_clr && (n < smp_e);
    samples += int'(sample_o);
    while (!eoc_o && n < 2000) begin
      @(negedge clk); n++;
      if (eosmp_o && smp_n < 0) smp_n = n;
      samples += int'(sample_o);
      strobes += int'(bit_stb_o);
      if (!eoc_o && data_o != prev) held_bad++;
      if (disturb && n == 4) begin start_i = 1'b1; smp_sel_i = ~s; res_sel_i = r + 2'd1; end
      if (disturb && n == 5) start_i = 1'b0;
      eosmp_clr_i = hold_clr && (n < smp_e);
    end
    exp_chan = (exp_chan + 1) % 16;
    chk(smp_n == smp_e, "R2 eosmp timing (R7 when clear held, R9 when disturbed)", smp_n, smp_e);
    chk(samples == smp_e, "R2 sample_o length", samples, smp_e);
    chk(strobes == exp_bits(r), "R3 strobe count", strobes, exp_bits(r));
    chk(n == tot_e, "R4 eoc timing (R8/R9 when disturbed)", n, tot_e);
    chk(data_o == tgt, "R5 result", data_o, tgt);
    chk(held_bad == 0, "R6 data held", held_bad, 0);
    chk(busy_o == 1'b0, "R10 single mode idle", busy_o, 0);
    chk(chan_o == 4'(exp_chan), "R10 channel step", chan_o, exp_chan);
    @(negedge clk); eoc_clr_i = 1'b1; eosmp_clr_i = 1'b1;
    @(negedge clk); eoc_clr_i = 1'b0; eosmp_clr_i = 1'b0;
    chk(!eoc_o && !eosmp_o, "R7 clear", {eoc_o, eosmp_o}, 0);
    chk(busy_o == 1'b0, "R8 no second conversion", busy_o, 0);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(!busy_o && !sample_o && !bit_stb_o && !eosmp_o && !eoc_o,
        "R1 reset outputs", {busy_o, sample_o, bit_stb_o, eosmp_o, eoc_o}, 0);
    chk(data_o == 0 && chan_o == 0, "R1 reset data/chan", data_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners: shortest, longest, set/clear collision, full scale
    run_conv(3'd0, 2'd0, 12'hFFF, 1'b0, 1'b0);
    run_conv(3'd7, 2'd3, 12'h02A, 1'b0, 1'b0);
    run_conv(3'd1, 2'd1, 12'h000, 1'b0, 1'b1);
    run_conv(3'd0, 2'd2, 12'h0FF, 1'b1, 1'b1);

    // constrained random
    for (int i = 0; i < 20; i++) begin
      logic [2:0] s = 3'($urandom % 6);
      logic [1:0] r = 2'($urandom % 4);
      logic [11:0] t = 12'($urandom % (1 << exp_bits(r)));
      run_conv(s, r, t, 1'($urandom % 2), 1'($urandom % 2));
    end

    // continuous mode, R10
    begin
      int n = 0;
      cont_i = 1'b1; smp_sel_i = 3'd0; res_sel_i = 2'd3; target = 12'h015;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      while (!eoc_o && n < 2000) begin @(negedge clk); n++; end
      exp_chan = (exp_chan + 1) % 16;
      chk(n == 18, "R10 first continuous result timing", n, 18);
      chk(busy_o && sample_o, "R10 next sampling begins", {busy_o, sample_o}, 3);
      chk(chan_o == 4'(exp_chan), "R10 channel step continuous", chan_o, exp_chan);
      chk(data_o == 12'h015, "R5 continuous first result", data_o, 12'h015);
      target = 12'h02B; cont_i = 1'b0;
      n = 0;
      @(negedge clk); n++; eoc_clr_i = 1'b1;
      @(negedge clk); n++; eoc_clr_i = 1'b0;
      while (!eoc_o && n < 2000) begin @(negedge clk); n++; end
      exp_chan = (exp_chan + 1) % 16;
      chk(n == 18, "R10 second continuous result timing", n, 18);
      chk(data_o == 12'h02B, "R5 continuous second result", data_o, 12'h02B);
      chk(!busy_o, "R10 stop after cont_i low", busy_o, 0);
      chk(chan_o == 4'(exp_chan), "R10 channel step second", chan_o, exp_chan);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule